// File: doc/BRIEF.md
# Multi-Device Identifier Search Engine

This block enumerates the 64-bit identifiers of every device sharing a single-wire open-drain bus. It does not drive the wire itself. It sits above a slot engine and asks that engine, through a request/acknowledge handshake, for four primitive operations: a bus reset with presence sampling, a byte write, a single-bit read and a single-bit write. Each search pass issues a reset, the search command byte, and then 64 rounds of read, read and write. The two reads return a bit and its complement, and the write returns the chosen branch to the devices.

Each identifier holds a family field in bits 0–7, a serial field in bits 8–55 and a check value over bits 0–55 in bits 56–63. The engine treats all 64 bits alike and does not verify the check value. It remembers the highest position at which it took the 0 branch at a disagreement, and the next pass takes the 1 branch there. A `start_i` pulse begins a new enumeration. Each `next_i` pulse runs one more pass. When no untried branch remains, the engine raises a finished flag. A missing presence response or a read pair of two ones aborts the pass with an error flag.

Top module: `rom_search_engine`

## Requirements
- R1: After reset, `op_req_o`, `code_valid_o`, `done_o`, `err_o` and `busy_o` are all 0.
- R2: A pass starts with a reset operation (kind 0) requested in the cycle after `start_i` or `next_i` is accepted. After presence is seen, the pass requests a byte write (kind 1) with data 0xF0.
- R3: For positions 1 to 64, least significant first, the engine requests two bit reads (kind 2) and then one bit write (kind 3) carrying the chosen bit in `op_wdata_o[0]`. A request is held with a stable kind until it is acknowledged, and bit p-1 of `code_o` equals the bit written at position p.
- R4: If the reset acknowledge reports no presence (`op_rbit_i`=0), `err_o` rises in the next cycle, the pass ends, and no code is reported.
- R5: If both reads at a position return 1, `err_o` rises in the next cycle, the pass ends, and no code is reported.
- R6: When the two reads differ, the written bit equals the first read. When both are 0 at a position above the recorded last-disagreement position, the engine writes 0.
- R7: At a disagreement, the engine writes 1 at the recorded position and repeats the previous pass's bit below it. Successive passes therefore report the codes in ascending order of their bit-reversed value.
- R8: `code_valid_o` is a one-cycle pulse in the cycle after the 64th write is acknowledged, and `code_o` then holds the found code.
- R9: `done_o` rises together with the `code_valid_o` of a pass that left no branch untried. After that, `next_i` starts no operation.
- R10: `start_i` in the idle state clears `done_o` and `err_o` and restarts enumeration from the first code.
- R11: `start_i` and `next_i` have no effect while a pass is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new enumeration (idle only) |
| next_i | input | 1 | Run one further pass (idle, not finished) |
| op_req_o | output | 1 | Operation request to the slot engine |
| op_kind_o | output | 2 | 0 reset, 1 byte write, 2 bit read, 3 bit write |
| op_wdata_o | output | 8 | Byte for kind 1, bit 0 for kind 3 |
| op_ack_i | input | 1 | One-cycle completion of the current request |
| op_rbit_i | input | 1 | Presence flag (kind 0) or bit read (kind 2), valid with ack |
| code_o | output | 64 | Identifier found by the latest pass |
| code_valid_o | output | 1 | One-cycle strobe for `code_o` |
| done_o | output | 1 | All identifiers enumerated |
| err_o | output | 1 | Last pass aborted (no presence or all-ones pair) |
| busy_o | output | 1 | A pass is in progress |

## Verification
Every result is due exactly one cycle after the edge that samples its cause. An accepted start or next shows a reset request in the following cycle. The acknowledge of the 64th write yields the valid strobe and the finished flag one cycle later, and a failing presence or all-ones acknowledge yields the error flag one cycle later. The bench's slot model predicts each of these from the acknowledges it hands out and compares the strobe on every falling edge. It also checks each requested operation kind, and each written bit against its own sorted list of expected codes, at the moment it acknowledges.

// File: rtl/rse_pkg.sv
package rse_pkg;
  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WBYTE = 2'd1,
    OP_RBIT  = 2'd2,
    OP_WBIT  = 2'd3
  } op_kind_t;

  typedef enum logic [2:0] {
    S_IDLE, S_RST, S_CMD, S_RDA, S_RDB, S_WR
  } seq_state_t;

  localparam logic [7:0] SEARCH_CMD = 8'hF0;

  // Branch choice for one position: agreement follows the bus, a
  // disagreement below the marker replays history, at it takes 1, above 0.
  function automatic logic pick_dir(input logic a, input logic b,
                                    input logic below, input logic at,
                                    input logic prev);
    if (a != b) return a;
    if (below)  return prev;
    return at;
  endfunction
endpackage

// File: rtl/rse_branch.sv
module rse_branch #(
  parameter int POS_W = 7
) (
  input  logic             bit_a_i,
  input  logic             bit_b_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [POS_W-1:0] last_disc_i,
  input  logic             prev_bit_i,
  output logic             dir_o,
  output logic             disc_hit_o,
  output logic             zero_taken_o
);
  logic below, at;
  assign below        = pos_i < last_disc_i;
  assign at           = pos_i == last_disc_i;
  assign disc_hit_o   = !bit_a_i && !bit_b_i;
  assign dir_o        = rse_pkg::pick_dir(bit_a_i, bit_b_i, below, at, prev_bit_i);
  assign zero_taken_o = disc_hit_o && !dir_o;
endmodule

// File: rtl/rse_ctrl.sv
module rse_ctrl #(
  parameter int CODE_W = 64,
  parameter int POS_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             next_i,
  input  logic             done_i,
  input  logic             dir_i,
  input  logic             op_ack_i,
  input  logic             op_rbit_i,
  output logic             op_req_o,
  output logic [1:0]       op_kind_o,
  output logic [7:0]       op_wdata_o,
  output logic             clear_o,
  output logic             pass_start_o,
  output logic             commit_o,
  output logic             pass_end_o,
  output logic             abort_o,
  output logic             pair_bad_o,
  output logic             bit_a_o,
  output logic             bit_b_o,
  output logic [POS_W-1:0] pos_o,
  output logic             busy_o
);
  import rse_pkg::*;

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(CODE_W);

  seq_state_t state_q, state_d;
  logic [POS_W-1:0] pos_q;
  logic a_q, b_q, ack, no_presence;
  op_kind_t kind;

  assign ack          = op_ack_i && op_req_o;
  assign clear_o      = (state_q == S_IDLE) && start_i;
  assign pass_start_o = clear_o || ((state_q == S_IDLE) && next_i && !done_i);
  assign no_presence  = (state_q == S_RST) && ack && !op_rbit_i;
  assign pair_bad_o   = (state_q == S_RDB) && ack && a_q && op_rbit_i;
  assign abort_o      = no_presence || pair_bad_o;
  assign commit_o     = (state_q == S_WR) && ack;
  assign pass_end_o   = commit_o && (pos_q == LAST_POS);

  always_comb begin
    unique case (state_q)
      S_RST:        kind = OP_RESET;
      S_CMD:        kind = OP_WBYTE;
      S_RDA, S_RDB: kind = OP_RBIT;
      default:      kind = OP_WBIT;
    endcase
  end

  assign op_req_o   = state_q != S_IDLE;
  assign op_kind_o  = kind;
  assign op_wdata_o = (state_q == S_CMD) ? SEARCH_CMD :
                      (state_q == S_WR)  ? {7'd0, dir_i} : 8'd0;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (pass_start_o) state_d = S_RST;
      S_RST:  if (ack) state_d = op_rbit_i ? S_CMD : S_IDLE;
      S_CMD:  if (ack) state_d = S_RDA;
      S_RDA:  if (ack) state_d = S_RDB;
      S_RDB:  if (ack) state_d = pair_bad_o ? S_IDLE : S_WR;
      S_WR:   if (ack) state_d = pass_end_o ? S_IDLE : S_RDA;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      pos_q   <= '0;
      a_q     <= 1'b0;
      b_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      if ((state_q == S_CMD) && ack) pos_q <= POS_W'(1);
      else if (commit_o)             pos_q <= pos_q + 1'b1;
      if ((state_q == S_RDA) && ack) a_q <= op_rbit_i;
      if ((state_q == S_RDB) && ack) b_q <= op_rbit_i;
    end
  end

  assign bit_a_o = a_q;
  assign bit_b_o = b_q;
  assign pos_o   = pos_q;
  assign busy_o  = state_q != S_IDLE;
endmodule

// File: rtl/rse_store.sv
module rse_store #(
  parameter int CODE_W = 64,
  parameter int POS_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              pass_start_i,
  input  logic              commit_i,
  input  logic              pass_end_i,
  input  logic              abort_i,
  input  logic              dir_i,
  input  logic              zero_taken_i,
  input  logic [POS_W-1:0]  pos_i,
  output logic              prev_bit_o,
  output logic [POS_W-1:0]  last_disc_o,
  output logic [CODE_W-1:0] code_o,
  output logic              valid_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int IDX_W = $clog2(CODE_W);

  logic [CODE_W-1:0] code_q;
  logic [POS_W-1:0]  last_disc_q, last_zero_q, lz_next, pos_m1;
  logic [IDX_W-1:0]  idx;
  logic valid_q, done_q, err_q;

  assign pos_m1  = pos_i - 1'b1;
  assign idx     = pos_m1[IDX_W-1:0];
  assign lz_next = (commit_i && zero_taken_i) ? pos_i : last_zero_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q      <= '0;
      last_disc_q <= '0;
      last_zero_q <= '0;
      valid_q     <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      valid_q <= pass_end_i;
      if (clear_i) begin
        code_q      <= '0;
        last_disc_q <= '0;
        done_q      <= 1'b0;
      end
      if (pass_start_i) begin
        last_zero_q <= '0;
        err_q       <= 1'b0;
      end
      if (commit_i) begin
        code_q[idx] <= dir_i;
        last_zero_q <= lz_next;
      end
      if (pass_end_i) begin
        last_disc_q <= lz_next;
        done_q      <= (lz_next == '0);
      end
      if (abort_i) err_q <= 1'b1;
    end
  end

  assign prev_bit_o  = code_q[idx];
  assign last_disc_o = last_disc_q;
  assign code_o      = code_q;
  assign valid_o     = valid_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
endmodule

// File: rtl/rom_search_engine.sv
module rom_search_engine #(
  parameter int CODE_W = 64,
  localparam int POS_W = $clog2(CODE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              next_i,
  output logic              op_req_o,
  output logic [1:0]        op_kind_o,
  output logic [7:0]        op_wdata_o,
  input  logic              op_ack_i,
  input  logic              op_rbit_i,
  output logic [CODE_W-1:0] code_o,
  output logic              code_valid_o,
  output logic              done_o,
  output logic              err_o,
  output logic              busy_o
);
  logic clear, pass_start, commit, pass_end, abort, pair_bad;
  logic bit_a, bit_b, dir, disc_hit, zero_taken, prev_bit;
  logic [POS_W-1:0] pos, last_disc;

  rse_ctrl #(.CODE_W(CODE_W), .POS_W(POS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .next_i(next_i),
    .done_i(done_o), .dir_i(dir), .op_ack_i(op_ack_i), .op_rbit_i(op_rbit_i),
    .op_req_o(op_req_o), .op_kind_o(op_kind_o), .op_wdata_o(op_wdata_o),
    .clear_o(clear), .pass_start_o(pass_start), .commit_o(commit),
    .pass_end_o(pass_end), .abort_o(abort), .pair_bad_o(pair_bad),
    .bit_a_o(bit_a), .bit_b_o(bit_b), .pos_o(pos), .busy_o(busy_o)
  );

  rse_branch #(.POS_W(POS_W)) u_branch (
    .bit_a_i(bit_a), .bit_b_i(bit_b), .pos_i(pos), .last_disc_i(last_disc),
    .prev_bit_i(prev_bit), .dir_o(dir), .disc_hit_o(disc_hit),
    .zero_taken_o(zero_taken)
  );

  rse_store #(.CODE_W(CODE_W), .POS_W(POS_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clear_i(clear), .pass_start_i(pass_start),
    .commit_i(commit), .pass_end_i(pass_end), .abort_i(abort), .dir_i(dir),
    .zero_taken_i(zero_taken), .pos_i(pos), .prev_bit_o(prev_bit),
    .last_disc_o(last_disc), .code_o(code_o), .valid_o(code_valid_o),
    .done_o(done_o), .err_o(err_o)
  );
endmodule

// File: rtl/rse_checker.sv
module rse_checker #(
  parameter int POS_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             op_req_o,
  input logic             op_ack_i,
  input logic [1:0]       op_kind_o,
  input logic [7:0]       op_wdata_o,
  input logic             code_valid_o,
  input logic             done_o,
  input logic             err_o,
  input logic             busy_o,
  input logic             commit,
  input logic             disc_hit,
  input logic             dir,
  input logic             pair_bad,
  input logic [POS_W-1:0] pos,
  input logic [POS_W-1:0] last_disc
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !op_req_o);
  a_r2_cmd_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (op_req_o && op_kind_o == 2'd1) |-> op_wdata_o == 8'hF0);
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op_req_o && !op_ack_i) |=> (op_req_o && $stable(op_kind_o)));
  a_r4_err_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid_o |-> !err_o);
  a_r5_pair_abort: assert property (@(posedge clk) disable iff (!rst_n)
    pair_bad |=> (err_o && !busy_o && !code_valid_o));
  a_r6_zero_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && disc_hit && pos > last_disc) |-> !dir);
  a_r7_one_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && disc_hit && pos == last_disc) |-> dir);
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid_o |=> !code_valid_o);
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);
endmodule

bind rom_search_engine rse_checker #(.POS_W(POS_W)) u_rse_checker (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_req_o(op_req_o),
  .op_ack_i(op_ack_i), .op_kind_o(op_kind_o), .op_wdata_o(op_wdata_o),
  .code_valid_o(code_valid_o), .done_o(done_o), .err_o(err_o),
  .busy_o(busy_o), .commit(commit), .disc_hit(disc_hit), .dir(dir),
  .pair_bad(pair_bad), .pos(pos), .last_disc(last_disc)
);

// File: tb/rom_search_engine_tb.sv
module rom_search_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 2;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, next_i = 1'b0;
  logic op_ack_i = 1'b0, op_rbit_i = 1'b0;
  logic op_req_o, code_valid_o, done_o, err_o, busy_o;
  logic [1:0] op_kind_o;
  logic [7:0] op_wdata_o;
  logic [63:0] code_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [63:0] devs[8];
  logic [63:0] exp_list[8];
  bit act[8];
  int ndev = 0, pass_idx = 0, step = 0, lat = 0;
  bit ghost = 0, pend_valid = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rom_search_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .next_i(next_i),
    .op_req_o(op_req_o), .op_kind_o(op_kind_o), .op_wdata_o(op_wdata_o),
    .op_ack_i(op_ack_i), .op_rbit_i(op_rbit_i), .code_o(code_o),
    .code_valid_o(code_valid_o), .done_o(done_o), .err_o(err_o),
    .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act_v,
                     input logic [63:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  function automatic logic [63:0] rev64(input logic [63:0] v);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = v[63-i];
    return r;
  endfunction

  // Expected enumeration order: ascending bit-reversed value (R7)
  task automatic build_expect();
    for (int i = 0; i < ndev; i++) exp_list[i] = devs[i];
    for (int i = 1; i < ndev; i++)
      for (int j = i; j > 0; j--)
        if (rev64(exp_list[j]) < rev64(exp_list[j-1])) begin
          logic [63:0] t;
          t = exp_list[j]; exp_list[j] = exp_list[j-1]; exp_list[j-1] = t;
        end
  endtask

  function automatic logic [1:0] exp_kind(input int s);
    if (s == 0) return 2'd0;
    if (s == 1) return 2'd1;
    return (((s - 2) % 3) == 2) ? 2'd3 : 2'd2;
  endfunction

  // Slot-engine and bus model: acknowledges requests, models wired-AND reads
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) chk(code_valid_o === pend_valid, "R8 valid strobe timing",
                     64'(code_valid_o), 64'(pend_valid));
      pend_valid = 0;
      if (op_ack_i) begin
        op_ack_i = 0; op_rbit_i = 0; lat = 0;
      end else if (op_req_o) begin
        if (lat < LAT) lat++;
        else begin
          chk(op_kind_o == exp_kind(step), "R3 operation order",
              64'(op_kind_o), 64'(exp_kind(step)));
          case (op_kind_o)
            2'd0: begin
              for (int i = 0; i < 8; i++) act[i] = 1;
              op_rbit_i = (ndev > 0) || ghost;
              step = op_rbit_i ? 1 : 0;
            end
            2'd1: begin
              chk(op_wdata_o == 8'hF0, "R2 search command", 64'(op_wdata_o), 64'hF0);
              step = 2;
            end
            2'd2: begin
              int bi; bit v;
              bi = (step - 2) / 3;
              v = 1;
              for (int i = 0; i < ndev; i++)
                if (act[i]) v = v & (((step - 2) % 3 == 0) ? devs[i][bi] : !devs[i][bi]);
              op_rbit_i = v;
              if (ghost && ((step - 2) % 3 == 1)) step = 0;
              else step++;
            end
            default: begin
              int bi;
              bi = (step - 2) / 3;
              chk(op_wdata_o[0] == exp_list[pass_idx][bi], "R6 R7 written branch bit",
                  64'(op_wdata_o[0]), 64'(exp_list[pass_idx][bi]));
              for (int i = 0; i < ndev; i++)
                if (devs[i][bi] != op_wdata_o[0]) act[i] = 0;
              step++;
              if (bi == 63) begin pend_valid = 1; pass_idx++; step = 0; end
            end
          endcase
          op_ack_i = 1;
        end
      end
    end
  end

  task automatic pulse(input bit is_start);
    @(negedge clk);
    if (is_start) start_i = 1; else next_i = 1;
    @(negedge clk);
    start_i = 0; next_i = 0;
  endtask

  task automatic wait_result();
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (code_valid_o || err_o) return;
    end
    chk(0, "R8 result timeout", 0, 1);
  endtask

  task automatic quiet_check(input string req, input int cycles);
    bit seen;
    seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (op_req_o) seen = 1;
    end
    chk(!seen, req, 64'(seen), 0);
  endtask

  task automatic full_search(input bit mid_next);
    build_expect();
    pass_idx = 0; step = 0;
    pulse(1);
    chk(op_req_o && op_kind_o == 2'd0, "R2 reset requested first",
        64'(op_kind_o), 0);
    for (int k = 0; k < ndev; k++) begin
      if (mid_next && k == 0) begin
        repeat (40) @(negedge clk);
        pulse(0); pulse(1);   // R11: both ignored mid-pass
      end
      wait_result();
      chk(code_o == exp_list[k], "R7 code order", code_o, exp_list[k]);
      chk(done_o == (k == ndev - 1), "R9 finished flag", 64'(done_o), 64'(k == ndev - 1));
      chk(!err_o, "R4 R5 no error", 64'(err_o), 0);
      if (k < ndev - 1) pulse(0);
    end
    pulse(0);
    quiet_check("R9 next ignored after finish", 30);
    chk(code_o == exp_list[ndev-1], "R9 code kept", code_o, exp_list[ndev-1]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!op_req_o && !code_valid_o && !done_o && !err_o && !busy_o,
        "R1 reset state", {59'd0, op_req_o, code_valid_o, done_o, err_o, busy_o}, 0);
    rst_n = 1;
    @(negedge clk);

    // single device, next and start pulsed mid-pass (R11)
    ndev = 1; devs[0] = 64'hC300_0012_3456_7828;
    full_search(1);

    // four devices sharing low bits
    ndev = 4;
    devs[0] = 64'hA5A5_0000_0000_1028; devs[1] = 64'h3C00_0000_0000_1028;
    devs[2] = 64'h0000_0000_0000_2028; devs[3] = 64'hFFFF_FFFF_FFFF_FFFF;
    full_search(0);

    // three devices that split at the extreme positions
    ndev = 3;
    devs[0] = 64'h0; devs[1] = 64'h8000_0000_0000_0000; devs[2] = 64'h1;
    full_search(0);

    // R10: restart after the first code
    ndev = 4;
    devs[0] = 64'h0000_0000_0000_0001; devs[1] = 64'h0000_0000_0000_0003;
    devs[2] = 64'h0000_0000_0000_0002; devs[3] = 64'h8000_0000_0000_0002;
    build_expect();
    pass_idx = 0; step = 0;
    pulse(1); wait_result();
    chk(code_o == exp_list[0], "R10 first code", code_o, exp_list[0]);
    pass_idx = 0;
    pulse(1); wait_result();
    chk(code_o == exp_list[0], "R10 restart gives first code", code_o, exp_list[0]);
    chk(!done_o, "R10 not finished", 64'(done_o), 0);

    // R4: no presence
    ndev = 0; ghost = 0; step = 0;
    pulse(1); wait_result();
    chk(err_o && !busy_o, "R4 no presence error", 64'({err_o, busy_o}), 64'b10);
    quiet_check("R4 no further operations", 20);

    // R5: presence but all-ones pair
    ghost = 1; step = 0;
    pulse(1); wait_result();
    chk(err_o && !busy_o, "R5 all-ones pair error", 64'({err_o, busy_o}), 64'b10);
    chk(!done_o, "R5 not finished", 64'(done_o), 0);
    quiet_check("R5 no further operations", 20);
    ghost = 0;

    // R10: start clears the error and restarts
    ndev = 1; devs[0] = 64'h0123_4567_89AB_CDEF;
    build_expect(); pass_idx = 0; step = 0;
    pulse(1);
    @(negedge clk);
    chk(!err_o, "R10 error cleared", 64'(err_o), 0);
    wait_result();
    chk(code_o == exp_list[0] && done_o, "R10 search after error", code_o, exp_list[0]);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule